// File: doc/BRIEF.md
# Magic-Word Serviced System Watchdog

This block is a system watchdog timer behind a simple 32-bit register port. Software programs a 16-bit timeout, may slow the countdown with a fixed prescaler, turns the timer on, and picks what happens when the count runs out: a one-cycle pulse on a reset output, or a one-cycle pulse on a non-maskable interrupt output. Expiry also reloads the counter so the timer keeps running.

The counter is only restarted by an ordered pair of 16-bit service writes: an arming word followed by a firing word. Any other service write drops the arming state. The enable bit cannot be cleared once set, so a runaway program cannot switch the timer off. A freeze bit holds the count, for example while a debugger has the processor halted. Two bus-monitor control fields are kept in the control word for a neighbouring block and are only stored and read back.

Top module: `sys_wdog`

## Requirements
- R1: After reset the control word reads 0x00000000, the count reads 0xFFFF and both pulse outputs are low.
- R2: The control word at word offset 0x4 holds timeout in bits 31:16, bus-monitor time in bits 15:8, bus-monitor enable in bit 7, freeze in bit 3, enable in bit 2, action select in bit 1 and prescale enable in bit 0; bits 6:4 always read 0 and every other bit reads back as written.
- R3: Once enable (bit 2) has been written as 1 it stays 1 until reset; a later write of 0 does not clear it, and the control readback shows 1.
- R4: While enable is 0 the counter never decrements and no pulse appears.
- R5: With enable set and freeze clear, the counter steps down by one every clock when prescale (bit 0) is 0, and once every PRESCALE_DIV clocks when it is 1.
- R6: A step taken while the count is 0 is an expiry: it raises a pulse for exactly that one cycle and reloads the counter from the timeout field.
- R7: On expiry the reset output pulses when action select (bit 1) is 1, and the interrupt output pulses when it is 0; the other output stays low.
- R8: Writing 0x556C to the service word (bits 15:0 of the word at offset 0xC) and then 0xAA39 as the next service write reloads the counter from the timeout field, whether or not the timer is enabled or frozen; writes to other registers in between do not break the pair, and a repeated 0x556C keeps the pair armed.
- R9: A service write of any other value, or 0xAA39 not directly preceded by 0x556C among service writes, leaves the counter unchanged and clears the arming state.
- R10: While freeze (bit 3) is 1 the counter holds its value and no pulse appears.
- R11: The word at offset 0x8 reads the live counter value in bits 15:0; writes to it have no effect on the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_addr | input | ADDR_W | Byte address of the 32-bit word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| wd_reset_o | output | 1 | One-cycle expiry pulse when reset action is selected |
| wd_nmi_o | output | 1 | One-cycle expiry pulse when interrupt action is selected |

## Verification
The hardest case to reach is a broken service sequence while the count differs from the timeout field. On a running timer the count drifts, and a reload is hard to tell apart from a normal countdown. The stimulus freezes the counter at a known value. Before each trial it writes a fresh timeout value, then sweeps every ordered pair from a small set of service words, including near-miss values. A trial counts as a reload only if the count jumps to the new timeout.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam logic [3:0]  OFF_CTRL   = 4'h4;
  localparam logic [3:0]  OFF_COUNT  = 4'h8;
  localparam logic [3:0]  OFF_SVC    = 4'hC;
  localparam logic [15:0] SVC_ARM    = 16'h556C;
  localparam logic [15:0] SVC_FIRE   = 16'hAA39;
  localparam logic [15:0] COUNT_INIT = 16'hFFFF;

  typedef struct packed {
    logic [15:0] timeout;
    logic [7:0]  bm_time;
    logic        bm_en;
    logic [2:0]  unused;
    logic        freeze;
    logic        enable;
    logic        act_reset;
    logic        pre_en;
  } ctrl_t;

  // Accept a written word: clear unused bits, keep enable sticky.
  function automatic ctrl_t ctrl_accept(ctrl_t cur, logic [31:0] wd);
    ctrl_t n;
    n        = ctrl_t'(wd);
    n.unused = 3'b000;
    n.enable = cur.enable | wd[2];
    return n;
  endfunction

  // Counter next-state: reload has priority, expiry reloads, a step decrements.
  function automatic logic [15:0] count_next(logic [15:0] cur, logic step,
                                             logic reload, logic [15:0] tmo);
    if (reload || (step && cur == 16'd0)) return tmo;
    if (step)                             return cur - 16'd1;
    return cur;
  endfunction

endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
  import wdog_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ctrl,
  input  logic [31:0] wdata,
  output ctrl_t       ctrl_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_accept(ctrl_q, wdata);
  end
endmodule

// File: rtl/wdog_service.sv
module wdog_service
  import wdog_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_svc,
  input  logic [15:0] svc_word,
  output logic        svc_reload
);
  logic armed_q;

  assign svc_reload = wr_svc && armed_q && (svc_word == SVC_FIRE);

  always_ff @(posedge clk) begin
    if (!rst_n)      armed_q <= 1'b0;
    else if (wr_svc) armed_q <= (svc_word == SVC_ARM);
  end
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int unsigned DIV = 32'h800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV < 2) begin : g_bypass
      assign tick = run;
    end else begin : g_div
      logic [PW-1:0] ps_q;
      assign tick = run && (ps_q == PW'(DIV - 1));
      always_ff @(posedge clk) begin
        if (!rst_n || clear) ps_q <= '0;
        else if (tick)       ps_q <= '0;
        else if (run)        ps_q <= ps_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step,
  input  logic        reload,
  input  logic        act_reset,
  input  logic [15:0] timeout,
  output logic [15:0] count_q,
  output logic        expire,
  output logic        rst_pulse_q,
  output logic        nmi_pulse_q
);
  assign expire = step && (count_q == 16'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q     <= COUNT_INIT;
      rst_pulse_q <= 1'b0;
      nmi_pulse_q <= 1'b0;
    end else begin
      count_q     <= count_next(count_q, step, reload, timeout);
      rst_pulse_q <= expire && act_reset;
      nmi_pulse_q <= expire && !act_reset;
    end
  end
endmodule

// File: rtl/sys_wdog.sv
module sys_wdog
  import wdog_pkg::*;
#(
  parameter int unsigned PRESCALE_DIV = 32'h800,
  parameter int unsigned ADDR_W       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              wd_reset_o,
  output logic              wd_nmi_o
);
  ctrl_t       ctrl_q;
  logic        sel_ctrl, sel_count, sel_svc;
  logic        en_w, freeze_w, act_w, run_w, ps_tick_w, step_w;
  logic        svc_reload_w, expire_w;
  logic [15:0] cnt_w, timeout_w;

  assign sel_ctrl  = (reg_addr == ADDR_W'(OFF_CTRL));
  assign sel_count = (reg_addr == ADDR_W'(OFF_COUNT));
  assign sel_svc   = (reg_addr == ADDR_W'(OFF_SVC));

  wdog_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(reg_wr && sel_ctrl),
    .wdata(reg_wdata), .ctrl_q(ctrl_q)
  );

  assign en_w      = ctrl_q.enable;
  assign freeze_w  = ctrl_q.freeze;
  assign act_w     = ctrl_q.act_reset;
  assign timeout_w = ctrl_q.timeout;
  assign run_w     = en_w && !freeze_w;

  wdog_service u_svc (
    .clk(clk), .rst_n(rst_n), .wr_svc(reg_wr && sel_svc),
    .svc_word(reg_wdata[15:0]), .svc_reload(svc_reload_w)
  );

  wdog_prescale #(.DIV(PRESCALE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run_w && ctrl_q.pre_en),
    .clear(svc_reload_w), .tick(ps_tick_w)
  );

  assign step_w = run_w && (ctrl_q.pre_en ? ps_tick_w : 1'b1);

  wdog_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step_w), .reload(svc_reload_w),
    .act_reset(act_w), .timeout(timeout_w), .count_q(cnt_w),
    .expire(expire_w), .rst_pulse_q(wd_reset_o), .nmi_pulse_q(wd_nmi_o)
  );

  always_comb begin
    reg_rdata = 32'h0;
    if (sel_ctrl)       reg_rdata = ctrl_q;
    else if (sel_count) reg_rdata = {16'h0, cnt_w};
  end
endmodule

// File: rtl/sys_wdog_chk.sv
module sys_wdog_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en_w,
  input logic        freeze_w,
  input logic        act_w,
  input logic [15:0] timeout_w,
  input logic [15:0] cnt_w,
  input logic        expire_w,
  input logic        svc_reload_w,
  input logic        wd_reset_o,
  input logic        wd_nmi_o
);
  assert_sticky_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en_w |=> en_w);

  assert_hold_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_w && !svc_reload_w) |=> $stable(cnt_w));

  assert_hold_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_w && !svc_reload_w) |=> $stable(cnt_w));

  assert_expire_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire_w |=> (cnt_w == $past(timeout_w)));

  assert_pulse_from_expiry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_reset_o || wd_nmi_o) |-> $past(expire_w));

  assert_reset_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reset_o |-> $past(act_w));

  assert_nmi_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wd_nmi_o |-> !$past(act_w));

  assert_service_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    svc_reload_w |=> (cnt_w == $past(timeout_w)));
endmodule

bind sys_wdog sys_wdog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_w(en_w), .freeze_w(freeze_w), .act_w(act_w),
  .timeout_w(timeout_w), .cnt_w(cnt_w), .expire_w(expire_w),
  .svc_reload_w(svc_reload_w), .wd_reset_o(wd_reset_o), .wd_nmi_o(wd_nmi_o)
);

// File: tb/sys_wdog_test.sv
module sys_wdog_test;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        wd_reset_o, wd_nmi_o;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  sys_wdog #(.PRESCALE_DIV(DIV), .ADDR_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wd_reset_o(wd_reset_o), .wd_nmi_o(wd_nmi_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; one rising edge captures the write.
  task automatic wr(logic [3:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] mk(int tmo, int bmt, bit bme, bit frz,
                                     bit en, bit act, bit pre);
    return {tmo[15:0], bmt[7:0], bme, 3'b000, frz, en, act, pre};
  endfunction

  function automatic logic [15:0] svc_word(int i);
    case (i)
      0: return 16'h556C;
      1: return 16'hAA39;
      2: return 16'h0000;
      3: return 16'h556D;
      4: return 16'hAA38;
      default: return 16'hFFFF;
    endcase
  endfunction

  task automatic service();
    wr(4'hC, 32'h0000556C);
    wr(4'hC, 32'h0000AA39);
  endtask

  // After a service, walk every edge up to and including the expiry edge.
  task automatic run_expiry(string req, int tmo, int div, bit act);
    int last;
    logic [31:0] v;
    last = (tmo + 1) * div;
    for (int e = 1; e <= last; e++) begin
      logic [15:0] ec;
      bit ep;
      @(negedge clk);
      ec = (e < last) ? 16'(tmo - e / div) : 16'(tmo);
      ep = (e == last);
      rd(4'h8, v);
      chk(req, {v[15:0], 14'b0, wd_reset_o, wd_nmi_o},
          {ec, 14'b0, ep & act, ep & ~act});
    end
    @(negedge clk);
    chk({req, " pulse one cycle"}, {30'b0, wd_reset_o, wd_nmi_o}, 32'h0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL run hung: actual=not finished expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v, exp;
    logic [15:0] prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(4'h4, v); chk("R1 ctrl", v, 32'h0);
    rd(4'h8, v); chk("R1 count", v, 32'h0000FFFF);
    chk("R1 pulses", {30'b0, wd_reset_o, wd_nmi_o}, 32'h0);

    // R2: field readback sweep with enable clear, unused bits forced
    for (int i = 0; i < 8; i++) begin
      logic [31:0] w;
      w = mk(40 + 97 * i, 8'hA5 ^ i, i[0], i[1], 1'b0, i[2], ~i[0]);
      w[6:4] = 3'(i);
      wr(4'h4, w);
      rd(4'h4, v);
      exp = w; exp[6:4] = 3'b000;
      chk("R2 readback", v, exp);
    end
    wr(4'h4, mk(40, 0, 0, 0, 0, 1, 0));

    // R4: disabled counter holds
    repeat (20) @(negedge clk);
    rd(4'h8, v); chk("R4 disabled hold", v, 32'h0000FFFF);
    chk("R4 no pulse", {30'b0, wd_reset_o, wd_nmi_o}, 32'h0);
    service();
    rd(4'h8, v); chk("R8 service while disabled", v, 32'd40);
    repeat (10) @(negedge clk);
    rd(4'h8, v); chk("R4 disabled after service", v, 32'd40);

    // R11: count register write ignored
    wr(4'h8, 32'h00001234);
    rd(4'h8, v); chk("R11 count write ignored", v, 32'd40);

    // R5/R6/R7: enable, reset action, no prescale
    wr(4'h4, mk(6, 0, 0, 0, 1, 1, 0));
    service();
    rd(4'h8, v); chk("R8 service reload", v, 32'd6);
    run_expiry("R6 R7 reset expiry", 6, 1, 1'b1);

    // R3: enable cannot be cleared; R7 interrupt action
    wr(4'h4, mk(6, 0, 0, 0, 0, 0, 0));
    rd(4'h4, v); chk("R3 sticky enable", v, mk(6, 0, 0, 0, 1, 0, 0));
    service();
    run_expiry("R3 R7 nmi expiry", 6, 1, 1'b0);

    // R5: prescaled countdown
    wr(4'h4, mk(3, 0, 0, 0, 1, 0, 1));
    service();
    run_expiry("R5 prescaled", 3, DIV, 1'b0);

    // R10: freeze
    wr(4'h4, mk(200, 0, 0, 0, 1, 1, 0));
    service();
    repeat (5) @(negedge clk);
    rd(4'h8, v); chk("R5 per-clock step", v, 32'd195);
    wr(4'h4, mk(200, 0, 0, 1, 1, 1, 0));
    rd(4'h8, v); chk("R10 freeze entry", v, 32'd194);
    repeat (12) @(negedge clk);
    rd(4'h8, v); chk("R10 frozen hold", v, 32'd194);
    chk("R10 no pulse", {30'b0, wd_reset_o, wd_nmi_o}, 32'h0);

    // R8/R9: all ordered pairs of service words while frozen
    prev = 16'd194;
    for (int i = 0; i < 36; i++) begin
      logic [15:0] a, b, tk;
      a = svc_word(i / 6);
      b = svc_word(i % 6);
      tk = 16'(300 + i);
      wr(4'h4, mk(tk, 0, 0, 1, 1, 1, 0));
      wr(4'hC, 32'h0);
      wr(4'hC, {16'h0, a});
      wr(4'hC, {16'h0, b});
      if (a == 16'h556C && b == 16'hAA39) prev = tk;
      rd(4'h8, v);
      chk("R9 R8 pair sweep", v, {16'h0, prev});
    end

    // R9: interrupted pair does not reload
    wr(4'h4, mk(500, 0, 0, 1, 1, 1, 0));
    wr(4'hC, 32'h556C); wr(4'hC, 32'h0); wr(4'hC, 32'hAA39);
    rd(4'h8, v); chk("R9 interrupted pair", v, {16'h0, prev});
    // R8: other-register write between the pair keeps it armed
    wr(4'hC, 32'h556C); wr(4'h4, mk(501, 0, 0, 1, 1, 1, 0)); wr(4'hC, 32'hAA39);
    rd(4'h8, v); chk("R8 pair across ctrl write", v, 32'd501);
    // R8: repeated arm word keeps pair armed
    wr(4'h4, mk(502, 0, 0, 1, 1, 1, 0));
    wr(4'hC, 32'h556C); wr(4'hC, 32'h556C); wr(4'hC, 32'hAA39);
    rd(4'h8, v); chk("R8 repeated arm", v, 32'd502);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule